// File: doc/BRIEF.md
# Start-Stop-Pause Timer with Toggle Output

This block is an up-counting timer paced by an external prescaled tick. A start control, when raised, zeroes the count and lets it run; a separate run control freezes and releases the count without losing its value. Each time the count reaches the compare value on a tick, a timeout occurs and the count returns to zero.

A timeout can raise a one-cycle interrupt pulse on every occurrence or only on every second one. A toggle output flips on every timeout. Its starting level is loaded while the timer is stopped, and a polarity control can invert the pin.

Top module: `toggle_timer`

## Requirements
- R1: After reset, `count` is 0 and `irq` is 0.
- R2: On the first cycle in which `start` is 1 after being 0, the next `count` is 0 and no timeout occurs, whatever `tick`, `run` and the old count are.
- R3: While `start` has been 1 for more than one cycle and `run` is 1, a cycle with `tick` high and `count` not equal to `cmp_val` raises `count` by one. A cycle with `tick` low leaves it unchanged.
- R4: With `run` at 0 the count holds through ticks. Setting `run` back to 1 resumes from the held value.
- R5: With `start` at 0 the count holds its value through ticks.
- R6: A timeout is a counting tick (as in R3) in a cycle where `count` equals `cmp_val`. On it, the next `count` is 0. With `cmp_val` of 0, every counting tick is a timeout.
- R7: With `irq_every2` at 0, `irq` is high for exactly the cycle after each timeout and low in every other cycle.
- R8: With `irq_every2` at 1, `irq` pulses only after the 2nd, 4th, 6th... timeout counted since the last start of the timer.
- R9: An internal toggle state flips on every timeout. `tout` equals that state when `out_inv` is 0 and its inverse when `out_inv` is 1.
- R10: Each cycle with `start` at 0 loads the toggle state from `out_init`, so one cycle later `tout` is `out_init ^ out_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| start | input | 1 | 1 runs the timer; a rise from 0 clears the count |
| run | input | 1 | 0 pauses counting, 1 continues |
| irq_every2 | input | 1 | 0 interrupt on every timeout, 1 on every second |
| out_init | input | 1 | Toggle level loaded while stopped |
| out_inv | input | 1 | 1 inverts the toggle output |
| cmp_val | input | W | Compare value |
| count | output | W | Current count |
| irq | output | 1 | One-cycle interrupt pulse |
| tout | output | 1 | Toggle output |

## Verification
The sharp coincidence is a restart that lands in the same cycle as a tick while the held count already equals the compare value. The bench parks the count at the compare value, stops the timer, and then raises `start` with `tick` high. A correct block shows a zero count, no interrupt pulse and no toggle of `tout` after that edge. The every-second-timeout sequence is also checked with continuous ticks, cycle by cycle, against positions worked out from the compare value.

// File: rtl/toggle_timer.sv
module toggle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic         run,
  input  logic         irq_every2,
  input  logic         out_init,
  input  logic         out_inv,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic         irq,
  output logic         tout
);

  logic         start_q;
  logic         half;
  logic         tog;
  logic [W-1:0] cnt;

  wire go  = start & ~start_q;
  wire adv = start & start_q & run & tick;
  wire tmo = adv & (cnt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      cnt     <= '0;
      half    <= 1'b0;
      tog     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      start_q <= start;
      irq     <= tmo & (~irq_every2 | half);
      if (go) begin
        cnt  <= '0;
        half <= 1'b0;
      end else begin
        if (adv) cnt <= tmo ? '0 : cnt + 1'b1;
        if (tmo) half <= ~half;
      end
      if (!start)   tog <= out_init;
      else if (tmo) tog <= ~tog;
    end
  end

  assign count = cnt;
  assign tout  = tog ^ out_inv;

endmodule

// File: rtl/toggle_timer_chk.sv
module toggle_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         start,
  input logic         run,
  input logic         out_init,
  input logic         out_inv,
  input logic [W-1:0] cmp_val,
  input logic [W-1:0] count,
  input logic         irq,
  input logic         tout
);

  logic was_on;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) was_on <= 1'b0;
    else        was_on <= start;

  wire counting = start && was_on && run && tick;

  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !was_on) |=> (count == '0 && !irq));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && count != cmp_val) |=> (count == W'($past(count) + 1'b1)));

  assert_pause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && was_on && !run) |=> $stable(count));

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && count == cmp_val) |=> (count == '0));

  assert_no_stray_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(counting && count == cmp_val) |=> !irq);

  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && count == cmp_val) |=> (tout != $past(tout)) || !$stable(out_inv));

  assert_load_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (tout == ($past(out_init) ^ out_inv)));

endmodule

bind toggle_timer toggle_timer_chk #(.W(W)) u_chk (.*);

// File: tb/sim_toggle_timer.sv
`timescale 1ns/1ps
module sim_toggle_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, run = 1'b0, irq_every2 = 1'b0;
  logic out_init = 1'b0, out_inv = 1'b0;
  logic [W-1:0] cmp_val = '0;
  logic [W-1:0] count;
  logic irq, tout;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  toggle_timer #(.W(W)) u0 (.clk, .rst_n, .tick, .start, .run, .irq_every2,
    .out_init, .out_inv, .cmp_val, .count, .irq, .tout);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic [W-1:0] c);
    cmp_val = c; tick = 1'b0; run = 1'b1; start = 1'b0;
    cyc(1);
    start = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_count;
    restart(16'd5);
    chk("R2 count after start", count, 0);
    tick = 1'b1; cyc(3);
    chk("R3 count after 3 ticks", count, 3);
    tick = 1'b0; cyc(2);
    chk("R3 no tick hold", count, 3);
    run = 1'b0; tick = 1'b1; cyc(3);
    chk("R4 paused hold", count, 3);
    run = 1'b1; cyc(1);
    chk("R4 resume", count, 4);
    cyc(1);
    chk("R6 reach cmp", count, 5);
    chk("R7 no irq before timeout", irq, 0);
    cyc(1);
    chk("R6 wrap to zero", count, 0);
    chk("R7 irq on timeout", irq, 1);
    cyc(1);
    chk("R7 irq single pulse", irq, 0);
    chk("R3 count after wrap", count, 1);
    start = 1'b0; cyc(3);
    chk("R5 stopped hold", count, 1);
    tick = 1'b0;
  endtask

  task automatic t_init_level;
    start = 1'b0; out_inv = 1'b0; out_init = 1'b1; cyc(1);
    chk("R10 init high", tout, 1);
    out_inv = 1'b1; #1;
    chk("R9 inverted init", tout, 0);
    out_init = 1'b0; cyc(1);
    chk("R10 init low inverted", tout, 1);
    out_inv = 1'b0; #1;
    chk("R10 init low", tout, 0);
  endtask

  task automatic t_every2;
    irq_every2 = 1'b1; out_init = 1'b0; out_inv = 1'b0;
    restart(16'd2);
    tick = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      cyc(1);
      chk("R6 count seq", count, k % 3);
      chk("R8 irq every second", irq, (k % 6 == 0) ? 1 : 0);
      chk("R9 toggle seq", tout, (k / 3) % 2);
    end
    tick = 1'b0; irq_every2 = 1'b0;
  endtask

  task automatic t_collision;
    out_init = 1'b0; out_inv = 1'b0;
    restart(16'd3);
    tick = 1'b1; cyc(3);
    chk("R3 at cmp", count, 3);
    tick = 1'b0; start = 1'b0; cyc(1);
    chk("R5 held at cmp", count, 3);
    start = 1'b1; tick = 1'b1; cyc(1);
    chk("R2 restart beats timeout count", count, 0);
    chk("R2 restart no irq", irq, 0);
    chk("R2 restart no toggle", tout, 0);
    tick = 1'b0;
  endtask

  task automatic t_cmp_zero;
    out_init = 1'b1; out_inv = 1'b0;
    restart(16'd0);
    tick = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      cyc(1);
      chk("R6 cmp zero count", count, 0);
      chk("R7 cmp zero irq", irq, 1);
      chk("R9 cmp zero toggle", tout, (k % 2 == 1) ? 0 : 1);
    end
    tick = 1'b0; cyc(1);
    chk("R7 irq drops", irq, 0);
  endtask

  initial begin
    cyc(3);
    t_reset;
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_count;
    t_init_level;
    t_every2;
    t_collision;
    t_cmp_zero;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule